// File: doc/BRIEF.md
# Oversampled Result Window Watchdog

This block watches a stream of 16-bit oversampled conversion results, each tagged with the channel number it came from. Whenever a result strobe arrives while monitoring is enabled, the block takes the upper twelve bits of the result. It compares that value against a 12-bit upper limit and a 12-bit lower limit. If the value lies outside the window, a sticky flag is raised. The flag stays up until software pulses a clear input.

Monitoring can cover every channel, or it can be narrowed to one programmed channel number. Any resolution setting used for conversions plays no part here. The twelve compared bits are always bits 15 down to 4 of the oversampled word, and the limits are always used at their full twelve bits. When the oversampled data has been shifted right, for example down to a 12-bit right-aligned value, only the low part of the compared field carries information. Software is then expected to program the upper limit bits as zero.

Top module: `ovs_window_monitor`

## Requirements
- R1: While the synchronous active-low reset is held, the flag output reads 0 at the next clock edge.
- R2: The compared value is bits [15:4] of the result; bits [3:0] never influence whether the flag sets.
- R3: A qualified result whose compared value is strictly greater than the upper limit sets the flag; equal to the upper limit does not.
- R4: A qualified result whose compared value is strictly less than the lower limit sets the flag; equal to the lower limit does not.
- R5: With the enable input at 0, no result sets the flag.
- R6: With the single-channel select at 1, only results whose channel tag equals the programmed channel can set the flag; with it at 0, results from every channel can.
- R7: Without the result-valid strobe, the data and channel inputs never set the flag.
- R8: Once set, the flag holds through later in-window results and idle cycles, and it returns to 0 one cycle after a clear pulse that arrives without a simultaneous out-of-window hit.
- R9: When an out-of-window hit and a clear pulse arrive in the same cycle, the flag is 1 afterwards.
- R10: The flag is registered: it changes at the clock edge that samples the strobe, and it is not visible earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid_i | input | 1 | One-cycle strobe marking a new oversampled result |
| res_data_i | input | 16 | Oversampled result word |
| res_chan_i | input | 3 | Channel tag of the result |
| wd_en_i | input | 1 | Monitoring enable |
| single_ch_i | input | 1 | 1 restricts monitoring to sel_chan_i |
| sel_chan_i | input | 3 | Channel watched in single-channel mode |
| thr_high_i | input | 12 | Upper window limit |
| thr_low_i | input | 12 | Lower window limit |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| flag_o | output | 1 | Sticky out-of-window flag |

## Verification
The bench sweeps all 4096 compared values against several limit pairs. These include the equal-limit case and a narrow upper limit that matches shifted data. A design that compared inclusively, or that used the wrong slice of the result, would flag exactly at the limits or react to the low nibble. A full 8-by-8 channel matrix in single-channel mode catches a filter that ignores the programmed channel or that inverts the mode bit. Targeted sequences cover clear colliding with a hit, where a clear-wins design would drop the flag. They also cover stickiness across in-window results, and they check the flag just before the sampling edge so that a combinational output path is exposed.

// File: rtl/owd_pkg.sv
// Package: shared defaults and the flag update action type.
// Assumes: widths on the top module override these defaults consistently.
package owd_pkg;

    localparam int unsigned DEF_RES_W = 16;  // oversampled result width
    localparam int unsigned DEF_CMP_W = 12;  // compared field and limit width
    localparam int unsigned DEF_CH_W  = 3;   // channel tag width

    // Action the sticky flag register takes on the next edge.
    typedef enum logic [1:0] {
        FLG_HOLD  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_CLEAR = 2'd2
    } flg_act_e;

endpackage

// File: rtl/owd_window_cmp.sv
// Module: owd_window_cmp
// Takes the top CMP_W bits of a RES_W-bit result and reports whether the
// value lies strictly above the upper limit or strictly below the lower one.
// Assumes: RES_W >= CMP_W; purely combinational.
module owd_window_cmp #(
    parameter int unsigned RES_W = owd_pkg::DEF_RES_W,
    parameter int unsigned CMP_W = owd_pkg::DEF_CMP_W
) (
    input  logic [RES_W-1:0] res_i,
    input  logic [CMP_W-1:0] hi_i,
    input  logic [CMP_W-1:0] lo_i,
    output logic             above_o,
    output logic             below_o
);

    localparam int unsigned DROP_W = RES_W - CMP_W;

    logic [CMP_W-1:0] cmp_val;

    // Select the most significant field of the result.
    assign cmp_val = res_i[RES_W-1 -: CMP_W];

    // The discarded low bits are deliberately left out of the comparison.
    generate
        if (DROP_W > 0) begin : g_drop
            logic unused_low_bits;
            assign unused_low_bits = ^res_i[DROP_W-1:0];
        end
    endgenerate

    // Strict window comparison against both limits.
    always_comb begin
        above_o = (cmp_val > hi_i);
        below_o = (cmp_val < lo_i);
    end

endmodule

// File: rtl/owd_chan_filter.sv
// Module: owd_chan_filter
// Decides whether a tagged result is in scope: every channel when
// single-channel mode is off, otherwise only the programmed channel.
// Assumes: channel tag and selection share the same width.
module owd_chan_filter #(
    parameter int unsigned CH_W = owd_pkg::DEF_CH_W
) (
    input  logic            single_i,
    input  logic [CH_W-1:0] tag_i,
    input  logic [CH_W-1:0] sel_i,
    output logic            in_scope_o
);

    // Scope decision: pass everything, or demand an exact tag match.
    always_comb begin
        in_scope_o = single_i ? (tag_i == sel_i) : 1'b1;
    end

endmodule

// File: rtl/owd_flag_reg.sv
// Module: owd_flag_reg
// Sticky flag: set by a qualified hit, cleared by a one-cycle clear pulse,
// a coincident hit outranks the clear.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module owd_flag_reg
    import owd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);

    flg_act_e act;

    // Priority encode the update: set first, then clear, else hold.
    always_comb begin
        if (hit_i)
            act = FLG_SET;
        else if (clr_i)
            act = FLG_CLEAR;
        else
            act = FLG_HOLD;
    end

    // Register the flag according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            case (act)
                FLG_SET:   flag_o <= 1'b1;
                FLG_CLEAR: flag_o <= 1'b0;
                default:   flag_o <= flag_o;
            endcase
        end
    end

endmodule

// File: rtl/ovs_window_monitor.sv
// Module: ovs_window_monitor
// Window watchdog for oversampled results. On each valid strobe, with the
// enable high and the channel in scope, the upper field of the result is
// compared with the limits; an out-of-window value raises a sticky flag.
// Assumes: res_valid_i is a single-cycle strobe; configuration is quasi-static.
module ovs_window_monitor #(
    parameter int unsigned RES_W = owd_pkg::DEF_RES_W,
    parameter int unsigned CMP_W = owd_pkg::DEF_CMP_W,
    parameter int unsigned CH_W  = owd_pkg::DEF_CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid_i,
    input  logic [RES_W-1:0] res_data_i,
    input  logic [CH_W-1:0]  res_chan_i,
    input  logic             wd_en_i,
    input  logic             single_ch_i,
    input  logic [CH_W-1:0]  sel_chan_i,
    input  logic [CMP_W-1:0] thr_high_i,
    input  logic [CMP_W-1:0] thr_low_i,
    input  logic             flag_clr_i,
    output logic             flag_o
);

    logic above;
    logic below;
    logic in_scope;
    logic hit;

    owd_window_cmp #(
        .RES_W (RES_W),
        .CMP_W (CMP_W)
    ) u_cmp (
        .res_i   (res_data_i),
        .hi_i    (thr_high_i),
        .lo_i    (thr_low_i),
        .above_o (above),
        .below_o (below)
    );

    owd_chan_filter #(
        .CH_W (CH_W)
    ) u_filt (
        .single_i   (single_ch_i),
        .tag_i      (res_chan_i),
        .sel_i      (sel_chan_i),
        .in_scope_o (in_scope)
    );

    // Qualify the window violation with strobe, enable and channel scope.
    always_comb begin
        hit = res_valid_i && wd_en_i && in_scope && (above || below);
    end

    owd_flag_reg u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .clr_i  (flag_clr_i),
        .flag_o (flag_o)
    );

endmodule

// File: rtl/owd_monitor_chk.sv
// Module: owd_monitor_chk
// Port-level properties of the window watchdog, bound to its top module.
// Assumes: observed only; drives nothing.
module owd_monitor_chk #(
    parameter int unsigned RES_W = owd_pkg::DEF_RES_W,
    parameter int unsigned CMP_W = owd_pkg::DEF_CMP_W,
    parameter int unsigned CH_W  = owd_pkg::DEF_CH_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid_i,
    input logic [RES_W-1:0] res_data_i,
    input logic [CH_W-1:0]  res_chan_i,
    input logic             wd_en_i,
    input logic             single_ch_i,
    input logic [CH_W-1:0]  sel_chan_i,
    input logic [CMP_W-1:0] thr_high_i,
    input logic [CMP_W-1:0] thr_low_i,
    input logic             flag_clr_i,
    input logic             flag_o
);

    logic [CMP_W-1:0] field;
    logic             outside;
    logic             scoped;
    logic             unused_chk_low;

    // Independent view of the compared field and the window test.
    assign field          = res_data_i[RES_W-1 -: CMP_W];
    assign outside        = (field > thr_high_i) || (field < thr_low_i);
    assign scoped         = !single_ch_i || (res_chan_i == sel_chan_i);
    assign unused_chk_low = ^res_data_i;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !flag_o);

    // R3 R4 R9
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && wd_en_i && scoped && outside) |=> flag_o);

    // R5 R7
    no_strobe_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(res_valid_i && wd_en_i)) |=> !flag_o);

    // R6
    other_chan_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && single_ch_i && (res_chan_i != sel_chan_i)) |=> !flag_o);

    // R2
    in_window_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !outside) |=> !flag_o);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(res_valid_i && wd_en_i && scoped && outside)) |=> !flag_o);

endmodule

bind ovs_window_monitor owd_monitor_chk #(
    .RES_W (RES_W),
    .CMP_W (CMP_W),
    .CH_W  (CH_W)
) u_chk (.*);

// File: tb/sim_ovs_window_monitor.sv
`timescale 1ns/1ps
module sim_ovs_window_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid_i = 1'b0;
    logic [15:0] res_data_i = '0;
    logic [2:0]  res_chan_i = '0;
    logic        wd_en_i = 1'b0;
    logic        single_ch_i = 1'b0;
    logic [2:0]  sel_chan_i = '0;
    logic [11:0] thr_high_i = '0;
    logic [11:0] thr_low_i = '0;
    logic        flag_clr_i = 1'b0;
    logic        flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ovs_window_monitor u0 (.*);

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: flag actual=%b expected=%b (data=%h chan=%0d hi=%h lo=%h)",
                     req, got, exp, res_data_i, res_chan_i, thr_high_i, thr_low_i);
        end
    endtask

    // Reference model of a qualified out-of-window hit.
    function automatic logic model_hit(input logic [15:0] d, input logic [2:0] ch);
        logic [11:0] v;
        v = d[15:4];
        return wd_en_i && (!single_ch_i || ch == sel_chan_i) &&
               ((v > thr_high_i) || (v < thr_low_i));
    endfunction

    // One strobe at a falling edge; flag is checked at the next falling edge.
    task automatic strobe(input logic [15:0] d, input logic [2:0] ch,
                          input logic clr, input logic exp, input string req);
        @(negedge clk);
        res_valid_i = 1'b1;
        res_data_i  = d;
        res_chan_i  = ch;
        flag_clr_i  = clr;
        @(negedge clk);
        res_valid_i = 1'b0;
        flag_clr_i  = 1'b0;
        chk(flag_o, exp, req);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] his [4];
        logic [11:0] los [4];
        his = '{12'h800, 12'hFFF, 12'h0FF, 12'h123};
        los = '{12'h400, 12'h000, 12'h000, 12'h123};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(flag_o, 1'b0, "R1 reset");
        rst_n = 1'b1;
        wd_en_i = 1'b1;

        // R2 R3 R4: full sweep of the compared field over several windows
        for (int p = 0; p < 4; p++) begin
            thr_high_i = his[p];
            thr_low_i  = los[p];
            for (int v = 0; v < 4096; v++) begin
                logic [15:0] d;
                d = {v[11:0], v[3:0] ^ 4'hA};
                strobe(d, v[2:0], 1'b0, model_hit(d, v[2:0]), "R3/R4 sweep");
                clear_flag();
            end
        end

        // R2: low nibble has no effect at the upper boundary
        thr_high_i = 12'h800;
        thr_low_i  = 12'h400;
        strobe(16'h800F, 3'd0, 1'b0, 1'b0, "R2 low nibble at high limit");
        strobe(16'h4000, 3'd0, 1'b0, 1'b0, "R2 low nibble zero at low limit");
        strobe(16'h8010, 3'd0, 1'b0, 1'b1, "R3 one above high limit");
        clear_flag();
        strobe(16'h3FFF, 3'd0, 1'b0, 1'b1, "R4 one below low limit");
        clear_flag();

        // R5: disabled monitor ignores out-of-window results
        wd_en_i = 1'b0;
        for (int k = 0; k < 8; k++)
            strobe({4'hF, 12'(k * 37)}, 3'(k), 1'b0, 1'b0, "R5 disabled");
        wd_en_i = 1'b1;

        // R6: single-channel matrix, then all-channel mode
        single_ch_i = 1'b1;
        for (int s = 0; s < 8; s++) begin
            sel_chan_i = 3'(s);
            for (int c = 0; c < 8; c++) begin
                strobe(16'hF000, 3'(c), 1'b0, (c == s), "R6 single channel");
                clear_flag();
            end
        end
        single_ch_i = 1'b0;
        sel_chan_i  = 3'd5;
        for (int c = 0; c < 8; c++) begin
            strobe(16'h0000, 3'(c), 1'b0, 1'b1, "R6 all channels");
            clear_flag();
        end

        // R7: no strobe, no evaluation
        @(negedge clk);
        res_data_i = 16'hFFFF;
        res_chan_i = 3'd1;
        repeat (5) @(negedge clk);
        chk(flag_o, 1'b0, "R7 no strobe");

        // R10: not visible before the sampling edge, visible after it
        @(negedge clk);
        res_valid_i = 1'b1;
        res_data_i  = 16'hFFFF;
        #3;
        chk(flag_o, 1'b0, "R10 before edge");
        @(negedge clk);
        res_valid_i = 1'b0;
        chk(flag_o, 1'b1, "R10 after edge");

        // R8: sticky through in-window results and idle cycles
        for (int k = 0; k < 5; k++)
            strobe(16'h6000, 3'(k), 1'b0, 1'b1, "R8 sticky in-window");
        repeat (4) @(negedge clk);
        chk(flag_o, 1'b1, "R8 sticky idle");
        strobe(16'h6000, 3'd0, 1'b1, 1'b0, "R8 clear with in-window result");

        // R9: set outranks clear, from both flag states
        strobe(16'hFFF0, 3'd2, 1'b1, 1'b1, "R9 hit with clear from 0");
        strobe(16'h0000, 3'd3, 1'b1, 1'b1, "R9 hit with clear from 1");
        clear_flag();
        chk(flag_o, 1'b0, "R8 clear alone");

        // R1: reset while flag set
        strobe(16'hFFFF, 3'd0, 1'b0, 1'b1, "R3 set before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(flag_o, 1'b0, "R1 reset clears flag");
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule